// File: doc/BRIEF.md
# Interrupt Controller Setup Sequencer

This block is the programming front end of a classic eight-input interrupt controller. A host reaches it through a byte-wide port that has a single address bit, which selects the even or the odd register. A write to the even register with bit 4 set starts a setup sequence. After that, each odd-register write is routed to the next setup word: the vector base, then the cascade layout, then the processor mode. Flags carried in the first word decide which of the later words are skipped. When the sequence ends, odd-register writes load the interrupt mask, and reading the odd register returns that mask.

The captured values go out to the priority logic: the vector base, the cascade byte, the slave identifier, the mode bits, the mask and a flag that shows setup is complete. A fixed-priority resolver is built into the block. It selects the lowest-numbered pending input that is not masked and forms a vector number from it. No request is raised until setup is complete.

Top module: `pic_init_seq`

## Requirements
- R1: After reset, `init_done`, `int_req`, `imr` and `vector_base` are all 0, and an odd-port read returns 0x00.
- R2: An even-port write with bit 4 set starts setup again from any state, including partway through a sequence. One cycle later, `init_done` is 0, `imr` is 0x00, `slave_id` is 7 and `upm_mode` is 0.
- R3: The first setup word latches its flags into outputs. Bit 0 is `w4_needed`, bit 1 is `single_mode` and bit 2 is `addr_interval`.
- R4: The first odd-port write after the first setup word loads `vector_base` with the full byte.
- R5: When `single_mode` is 0, the second odd-port write loads `cascade_cfg` with the full byte and loads `slave_id` with its bits [2:0].
- R6: When `single_mode` is 1, the cascade word is skipped. The odd-port write that follows the vector base goes to the mode word if `w4_needed` is 1, and otherwise it ends setup.
- R7: When `w4_needed` is 1, the last setup write sets `upm_mode` from bit 0. When `w4_needed` is 0, the mode word is skipped and `upm_mode` stays 0.
- R8: After setup is complete, `init_done` is 1. Each odd-port write then loads `imr`, where a 1 masks an input, and an odd-port read returns `imr`.
- R9: `int_req` is 1 when some input has `irq_in` high and its `imr` bit low. `vector` is `vector_base[7:3]` followed by the 3-bit index of the lowest such input, and input 0 has the highest priority.
- R10: `int_req` stays 0 while `init_done` is 0, whatever `irq_in` and `imr` hold.
- R11: An even-port write with bit 4 clear changes neither `init_done` nor `imr`.
- R12: An odd-port write made before the first setup word has no effect, and `imr` stays 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 1 | 0 selects the even register, 1 selects the odd register |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data: `imr` on an odd read, otherwise 0 |
| irq_in | input | 8 | Pending interrupt inputs |
| init_done | output | 1 | Setup sequence complete |
| vector_base | output | 8 | Vector base byte |
| cascade_cfg | output | 8 | Cascade byte |
| slave_id | output | 3 | Slave identifier |
| single_mode | output | 1 | Non-cascaded operation |
| addr_interval | output | 1 | Address-interval flag |
| w4_needed | output | 1 | Mode word expected |
| upm_mode | output | 1 | Microprocessor mode |
| imr | output | 8 | Interrupt mask |
| int_req | output | 1 | Unmasked request pending |
| vector | output | 8 | Resolved vector number |

## Verification
The sequencer is driven with all four flag combinations of the first word: cascade with the mode word, single with the mode word, cascade without it, and single without it. The point at which `init_done` rises and the register that each odd-port write lands in show whether words are skipped correctly. A restart in the middle of a sequence shows that a new first word takes priority over a sequence already under way. Ignored even-port commands and odd-port writes made before any setup show that neither stray write touches the mask. The resolver is tried with several pending patterns: all pending inputs masked, two inputs pending at once, and input 0 pending. These tell apart the masking, the priority order and the way the vector is formed.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE  = 3'd0,
    SEQ_W2    = 3'd1,
    SEQ_W3    = 3'd2,
    SEQ_W4    = 3'd3,
    SEQ_READY = 3'd4
  } seq_state_e;

  localparam int START_BIT  = 4;
  localparam int FLAG_W4    = 0;
  localparam int FLAG_SNGL  = 1;
  localparam int FLAG_ADI   = 2;
  localparam int MODE_UPM   = 0;
endpackage

// File: rtl/pic_seq_fsm.sv
module pic_seq_fsm
  import pic_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_hit,
  input  logic       odd_wr,
  input  logic       single_q,
  input  logic       w4_q,
  output seq_state_e state
);
  seq_state_e state_d;
  logic       state_en;

  always_comb begin
    state_d = state;
    if (start_hit) begin
      state_d = SEQ_W2;
    end else if (odd_wr) begin
      unique case (state)
        SEQ_W2:  state_d = !single_q ? SEQ_W3 : (w4_q ? SEQ_W4 : SEQ_READY);
        SEQ_W3:  state_d = w4_q ? SEQ_W4 : SEQ_READY;
        SEQ_W4:  state_d = SEQ_READY;
        default: state_d = state;
      endcase
    end
  end

  assign state_en = start_hit | odd_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state <= SEQ_IDLE;
    else if (state_en) state <= state_d;
  end

  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    start_hit |=> state == SEQ_W2); // R2
  AST_W3_ONLY_CASCADE: assert property (@(posedge clk) disable iff (!rst_n)
    state == SEQ_W3 |-> !single_q); // R6
  AST_W4_ONLY_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    state == SEQ_W4 |-> w4_q); // R7
endmodule

// File: rtl/pic_cfg_bank.sv
module pic_cfg_bank
  import pic_pkg::*;
#(
  parameter int DW   = 8,
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  seq_state_e      state,
  input  logic            start_hit,
  input  logic            odd_wr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   base_q,
  output logic [DW-1:0]   casc_q,
  output logic [IDXW-1:0] sid_q,
  output logic            single_q,
  output logic            adi_q,
  output logic            w4_q,
  output logic            upm_q,
  output logic [DW-1:0]   imr_q
);
  localparam logic [IDXW-1:0] SID_DEFAULT = '1;

  logic            base_en, casc_en, mode_en, imr_en, flags_en;
  logic [DW-1:0]   imr_d;
  logic [IDXW-1:0] sid_d;
  logic            upm_d;

  always_comb begin
    flags_en = start_hit;
    base_en  = odd_wr && (state == SEQ_W2);
    casc_en  = odd_wr && (state == SEQ_W3);
    mode_en  = start_hit || (odd_wr && (state == SEQ_W4));
    imr_en   = start_hit || (odd_wr && (state == SEQ_READY));
    imr_d    = start_hit ? '0 : wdata;
    sid_d    = start_hit ? SID_DEFAULT : wdata[IDXW-1:0];
    upm_d    = start_hit ? 1'b0 : wdata[MODE_UPM];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      single_q <= 1'b0;
      adi_q    <= 1'b0;
      w4_q     <= 1'b0;
    end else if (flags_en) begin
      single_q <= wdata[FLAG_SNGL];
      adi_q    <= wdata[FLAG_ADI];
      w4_q     <= wdata[FLAG_W4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_en) base_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       casc_q <= '0;
    else if (casc_en) casc_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    sid_q <= SID_DEFAULT;
    else if (casc_en || start_hit) sid_q <= sid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       upm_q <= 1'b0;
    else if (mode_en) upm_q <= upm_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      imr_q <= '0;
    else if (imr_en) imr_q <= imr_d;
  end

  AST_MASK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    start_hit |=> imr_q == '0); // R2
  AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state != SEQ_READY && !start_hit) |=> $stable(imr_q)); // R12
  AST_UPM_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_hit && !(odd_wr && state == SEQ_W4)) |=> $stable(upm_q)); // R7
endmodule

// File: rtl/pic_prio_resolver.sv
module pic_prio_resolver #(
  parameter int NIRQ = 8,
  parameter int DW   = 8,
  localparam int IDXW = $clog2(NIRQ)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic [NIRQ-1:0] irq_in,
  input  logic [NIRQ-1:0] mask,
  input  logic [DW-1:0]   base,
  output logic            req,
  output logic [DW-1:0]   vector
);
  logic [NIRQ-1:0] live;
  logic [IDXW-1:0] win;

  for (genvar g = 0; g < NIRQ; g++) begin : g_live
    assign live[g] = irq_in[g] & ~mask[g];
  end

  always_comb begin
    win = '0;
    for (int i = NIRQ - 1; i >= 0; i--) begin
      if (live[i]) win = IDXW'(i);
    end
  end

  assign req    = enable & (|live);
  assign vector = {base[DW-1:IDXW], win};

  AST_NO_REQ_IN_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !req); // R10
  AST_WINNER_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (irq_in[win] && !mask[win])); // R9
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_pkg::*;
#(
  parameter int NIRQ = 8,
  localparam int DW   = 8,
  localparam int IDXW = $clog2(NIRQ)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic            addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic [NIRQ-1:0] irq_in,
  output logic            init_done,
  output logic [DW-1:0]   vector_base,
  output logic [DW-1:0]   cascade_cfg,
  output logic [IDXW-1:0] slave_id,
  output logic            single_mode,
  output logic            addr_interval,
  output logic            w4_needed,
  output logic            upm_mode,
  output logic [NIRQ-1:0] imr,
  output logic            int_req,
  output logic [DW-1:0]   vector
);
  seq_state_e state;
  logic       start_hit, odd_wr;

  assign start_hit = wr_en & ~addr & wdata[START_BIT];
  assign odd_wr    = wr_en & addr;

  pic_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_hit (start_hit),
    .odd_wr    (odd_wr),
    .single_q  (single_mode),
    .w4_q      (w4_needed),
    .state     (state)
  );

  pic_cfg_bank #(.DW(DW), .IDXW(IDXW)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .start_hit (start_hit),
    .odd_wr    (odd_wr),
    .wdata     (wdata),
    .base_q    (vector_base),
    .casc_q    (cascade_cfg),
    .sid_q     (slave_id),
    .single_q  (single_mode),
    .adi_q     (addr_interval),
    .w4_q      (w4_needed),
    .upm_q     (upm_mode),
    .imr_q     (imr)
  );

  assign init_done = (state == SEQ_READY);
  assign rdata     = (rd_en && addr) ? imr : '0;

  pic_prio_resolver #(.NIRQ(NIRQ), .DW(DW)) u_res (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (init_done),
    .irq_in (irq_in),
    .mask   (imr),
    .base   (vector_base),
    .req    (int_req),
    .vector (vector)
  );

  AST_OTHER_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && !wdata[START_BIT]) |=> ($stable(init_done) && $stable(imr))); // R11
endmodule

// File: tb/tb_pic_init_seq.sv
module tb_pic_init_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = 8'h00, irq_in = 8'h00;
  logic [7:0] rdata, vector_base, cascade_cfg, imr, vector;
  logic [2:0] slave_id;
  logic       init_done, single_mode, addr_interval, w4_needed, upm_mode, int_req;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pic_init_seq dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .init_done(init_done),
    .vector_base(vector_base), .cascade_cfg(cascade_cfg), .slave_id(slave_id),
    .single_mode(single_mode), .addr_interval(addr_interval), .w4_needed(w4_needed),
    .upm_mode(upm_mode), .imr(imr), .int_req(int_req), .vector(vector));

  // {addr, data, expected init_done, expected mask read-back}
  localparam logic [17:0] STEPS [14] = '{
    {1'b0, 8'h11, 1'b0, 8'h00}, {1'b1, 8'h20, 1'b0, 8'h00},
    {1'b1, 8'h04, 1'b0, 8'h00}, {1'b1, 8'h01, 1'b1, 8'h00},
    {1'b1, 8'hFB, 1'b1, 8'hFB}, {1'b0, 8'h0A, 1'b1, 8'hFB},
    {1'b0, 8'h13, 1'b0, 8'h00}, {1'b1, 8'h28, 1'b0, 8'h00},
    {1'b1, 8'h01, 1'b1, 8'h00}, {1'b1, 8'h3C, 1'b1, 8'h3C},
    {1'b0, 8'h10, 1'b0, 8'h00}, {1'b1, 8'h48, 1'b0, 8'h00},
    {1'b1, 8'h02, 1'b1, 8'h00}, {1'b1, 8'hFF, 1'b1, 8'hFF}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; addr = 1'b0; wdata = 8'h00;
  endtask

  task automatic rd_mask(output logic [7:0] v);
    addr = 1'b1; rd_en = 1'b1; #1 v = rdata; rd_en = 1'b0; addr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_mask(m);
    chk("R1 mask read", m, 8'h00);
    chk("R1 init_done", {7'b0, init_done}, 8'h00);
    chk("R1 int_req", {7'b0, int_req}, 8'h00);
    chk("R1 base", vector_base, 8'h00);

    wr(1'b1, 8'h55);
    rd_mask(m);
    chk("R12 early odd write", m, 8'h00);
    chk("R12 init_done", {7'b0, init_done}, 8'h00);

    for (int i = 0; i < 14; i++) begin
      wr(STEPS[i][17], STEPS[i][16:9]);
      rd_mask(m);
      chk("R6/R7/R8/R11 table done", {7'b0, init_done}, {7'b0, STEPS[i][8]});
      chk("R8 table mask", m, STEPS[i][7:0]);
    end

    // cascade with mode word, fields checked one by one
    wr(1'b0, 8'h15);
    chk("R3 single", {7'b0, single_mode}, 8'h00);
    chk("R3 adi", {7'b0, addr_interval}, 8'h01);
    chk("R3 w4", {7'b0, w4_needed}, 8'h01);
    chk("R2 slave id 7", {5'b0, slave_id}, 8'h07);
    wr(1'b1, 8'h2F);
    chk("R4 base", vector_base, 8'h2F);
    wr(1'b1, 8'h04);
    chk("R5 cascade", cascade_cfg, 8'h04);
    chk("R5 slave id", {5'b0, slave_id}, 8'h04);
    wr(1'b1, 8'h01);
    chk("R7 upm set", {7'b0, upm_mode}, 8'h01);
    chk("R8 done", {7'b0, init_done}, 8'h01);
    wr(1'b1, 8'hF0);
    @(negedge clk); irq_in = 8'h6C; #1;
    chk("R9 req", {7'b0, int_req}, 8'h01);
    chk("R9 vector idx2", vector, 8'h2A);
    irq_in = 8'hF0; #1;
    chk("R9 all masked", {7'b0, int_req}, 8'h00);
    irq_in = 8'h09; #1;
    chk("R9 vector idx0", vector, 8'h28);

    // restart mid-sequence; pending input during setup
    irq_in = 8'h01;
    wr(1'b0, 8'h11);
    chk("R10 no req in setup", {7'b0, int_req}, 8'h00);
    chk("R2 upm cleared", {7'b0, upm_mode}, 8'h00);
    wr(1'b1, 8'h30);
    wr(1'b0, 8'h13);
    chk("R2 restart done low", {7'b0, init_done}, 8'h00);
    wr(1'b1, 8'h40);
    chk("R2 restart base", vector_base, 8'h40);
    chk("R6 cascade untouched", cascade_cfg, 8'h04);
    wr(1'b1, 8'h01);
    chk("R7 upm again", {7'b0, upm_mode}, 8'h01);
    chk("R6 done after w4", {7'b0, init_done}, 8'h01);
    chk("R9 req after setup", {7'b0, int_req}, 8'h01);

    // single without mode word: upm must fall to 0
    wr(1'b0, 8'h12);
    wr(1'b1, 8'h50);
    chk("R7 skip w4 done", {7'b0, init_done}, 8'h01);
    chk("R7 upm zero", {7'b0, upm_mode}, 8'h00);
    wr(1'b0, 8'h08);
    chk("R11 done kept", {7'b0, init_done}, 8'h01);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule